// File: doc/BRIEF.md
# Cache Test-and-Clean Sequencer

This block keeps the valid and dirty state of a set-associative write-back data cache and answers maintenance requests from a control-register port. Its main request is "test and clean". The block looks at a small window of lines, starting at a rotating pointer. If any line in that window is dirty, the block writes exactly that one line back through a request/acknowledge port and marks it clean. It then returns a status word. Bit 30 of that word reads 1 only when no dirty line is left anywhere in the cache, and the same bit also drives a zero-flag output. Software flushes the whole cache by repeating the request until the flag reports clean. The block does not run one long flush of its own.

A second test request works the same way, with one addition: once the cache holds no dirty line, it clears every valid bit, one set per clock. Two single-line requests take a set/way operand word. The way index sits in the top bits of that word and the set index starts at bit 5. One request cleans the addressed line. The other cleans the line and then invalidates it. A running dirty-line counter supplies the global clean flag in a single cycle, so no full scan is needed. The cache itself drives the fill and store ports, which mark lines valid and dirty.

Top module: `dcache_tclean_seq`

## Requirements
- R1: After reset, req_ready is 1, done is 0 and wb_req is 0. The status word is 32'h4000_0000 and zflag is 1. The scan pointer starts at line index 0.
- R2: A store on a valid line (store_en, with line index = {set, way}) makes that line dirty. A store on a line that is not valid is ignored: the line is never written back and the status still reports clean.
- R3: Op code 0 is test-and-clean. It examines SCAN_LINES consecutive line indices, modulo the line count, starting at the pointer. If any of them is dirty, it writes back exactly the first dirty one in that order, marks it clean and moves the pointer to that index + 1. If none is dirty, the pointer moves forward by SCAN_LINES and nothing is written back.
- R4: wb_req stays high with a stable wb_set/wb_way until wb_ack is seen. The dirty bit is cleared on the acknowledged edge, and done pulses for one cycle right after that edge (the invalidate sweep of R8 comes first when it applies).
- R5: A test request that finds no dirty line raises done in the second cycle after the edge that accepts it, with no write-back.
- R6: At done, status bit 30 is 1 if no dirty line remains and 0 otherwise. All other status bits are 0, and zflag equals bit 30. Status holds until the next done.
- R7: Repeating op 0 until bit 30 reads 1 writes back every dirty line exactly once.
- R8: Op code 1 is test-clean-invalidate. It behaves as op 0. When no dirty line remains after the step, it also clears every valid bit, one set per cycle, so done comes SETS+2 cycles after acceptance when nothing was written back.
- R9: In the set/way operand, the way is bits 31 down to 32-A (A = log2 WAYS) and the set is bits S+4 down to 5 (S = log2 SETS). All other bits are ignored.
- R10: Op code 2 writes back the addressed line only if it is dirty. Op code 3 does the same and then invalidates the line, so later stores to it are ignored.
- R11: req_ready is low from the accepting edge until done, and a request is taken only while req_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fill_en | input | 1 | Line fill: mark line valid |
| fill_set | input | SET_W | Set of the filled line |
| fill_way | input | WAY_W | Way of the filled line |
| store_en | input | 1 | Store hit: mark line dirty if valid |
| store_set | input | SET_W | Set of the stored line |
| store_way | input | WAY_W | Way of the stored line |
| req_valid | input | 1 | Maintenance request strobe |
| req_op | input | 2 | 0 test-clean, 1 test-clean-invalidate, 2 clean line, 3 clean+invalidate line |
| req_operand | input | 32 | Set/way operand word for ops 2 and 3 |
| req_ready | output | 1 | Idle, request can be taken |
| done | output | 1 | One-cycle completion pulse |
| status | output | 32 | Status word, bit 30 = cache fully clean |
| zflag | output | 1 | Zero flag, copy of status bit 30 |
| wb_req | output | 1 | Write-back request for one line |
| wb_set | output | SET_W | Set of the line to write back |
| wb_way | output | WAY_W | Way of the line to write back |
| wb_ack | input | 1 | Write-back accepted |

## Verification
The assertions assume that fill and store strobes arrive only while req_ready is high, so that no line changes state during a scan, a write-back or a sweep. They also assume that wb_ack is raised only while wb_req is high. The bench drives fills and stores between requests only, and raises the acknowledge only after it has seen wb_req, after a random delay of zero to two cycles. Random fill and store patterns come from a fixed seed. They include stores to lines that are not valid, and operand words with stray bits set in the fields that are ignored.

// File: rtl/tcs_pkg.sv
package tcs_pkg;
  typedef enum logic [1:0] {
    OP_TC      = 2'd0,
    OP_TCI     = 2'd1,
    OP_LINE_C  = 2'd2,
    OP_LINE_CI = 2'd3
  } tcs_op_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SCAN  = 2'd1,
    ST_WB    = 2'd2,
    ST_SWEEP = 2'd3
  } tcs_state_e;

  localparam int unsigned CLEAN_BIT = 30;

  // Status word: only the "all clean" bit carries information.
  function automatic logic [31:0] status_word(input logic all_clean);
    logic [31:0] w;
    w = '0;
    w[CLEAN_BIT] = all_clean;
    return w;
  endfunction

  function automatic logic op_is_test(input tcs_op_e op);
    return (op == OP_TC) || (op == OP_TCI);
  endfunction
endpackage

// File: rtl/tcs_line_state.sv
module tcs_line_state #(
  parameter int unsigned SETS = 16,
  parameter int unsigned WAYS = 4,
  localparam int unsigned SET_W  = $clog2(SETS),
  localparam int unsigned WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1,
  localparam int unsigned LINES  = SETS * WAYS,
  localparam int unsigned LIDX_W = SET_W + WAY_W,
  localparam int unsigned CNT_W  = $clog2(LINES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fill_en,
  input  logic [LIDX_W-1:0] fill_idx,
  input  logic              store_en,
  input  logic [LIDX_W-1:0] store_idx,
  input  logic              clr_en,
  input  logic [LIDX_W-1:0] clr_idx,
  input  logic              clr_inval,
  input  logic              sweep_en,
  input  logic [SET_W-1:0]  sweep_set,
  output logic [LINES-1:0]  valid_vec,
  output logic [LINES-1:0]  dirty_vec,
  output logic [CNT_W-1:0]  dirty_cnt,
  output logic [CNT_W-1:0]  cnt_next
);
  logic [LINES-1:0] valid_q, dirty_q, valid_n, dirty_n;
  logic [CNT_W-1:0] cnt_q;
  logic             inc;
  logic [CNT_W-1:0] dec;

  // Next-state of the line bits: clear and sweep win over a store to the same line.
  always_comb begin
    valid_n = valid_q;
    dirty_n = dirty_q;
    dec     = '0;
    if (fill_en) valid_n[fill_idx] = 1'b1;
    if (store_en && valid_q[store_idx]) dirty_n[store_idx] = 1'b1;
    if (clr_en) begin
      dirty_n[clr_idx] = 1'b0;
      if (clr_inval) valid_n[clr_idx] = 1'b0;
      dec = CNT_W'(dirty_q[clr_idx]);
    end
    if (sweep_en) begin
      for (int w = 0; w < WAYS; w++) begin
        valid_n[{sweep_set, WAY_W'(w)}] = 1'b0;
        dirty_n[{sweep_set, WAY_W'(w)}] = 1'b0;
        dec = dec + CNT_W'(dirty_q[{sweep_set, WAY_W'(w)}]);
      end
    end
    inc = store_en && !dirty_q[store_idx] && dirty_n[store_idx];
  end

  assign cnt_next = cnt_q + CNT_W'(inc) - dec;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
      dirty_q <= '0;
      cnt_q   <= '0;
    end else begin
      valid_q <= valid_n;
      dirty_q <= dirty_n;
      cnt_q   <= cnt_next;
    end
  end

  assign valid_vec = valid_q;
  assign dirty_vec = dirty_q;
  assign dirty_cnt = cnt_q;
endmodule

// File: rtl/tcs_scan_pick.sv
module tcs_scan_pick #(
  parameter int unsigned LINES      = 64,
  parameter int unsigned SCAN_LINES = 4,
  localparam int unsigned LIDX_W = $clog2(LINES)
) (
  input  logic [LINES-1:0]  dirty_vec,
  input  logic [LIDX_W-1:0] ptr,
  output logic              found,
  output logic [LIDX_W-1:0] pick_idx
);
  logic [LIDX_W-1:0] win_idx [SCAN_LINES];
  logic [SCAN_LINES-1:0] hit;

  for (genvar k = 0; k < SCAN_LINES; k++) begin : g_win
    assign win_idx[k] = ptr + LIDX_W'(k);
    assign hit[k]     = dirty_vec[win_idx[k]];
  end

  // Lowest window offset wins.
  always_comb begin
    found    = |hit;
    pick_idx = ptr;
    for (int k = SCAN_LINES - 1; k >= 0; k--) begin
      if (hit[k]) pick_idx = win_idx[k];
    end
  end
endmodule

// File: rtl/dcache_tclean_seq.sv
module dcache_tclean_seq
  import tcs_pkg::*;
#(
  parameter int unsigned SETS       = 16,
  parameter int unsigned WAYS       = 4,
  parameter int unsigned SCAN_LINES = 4,
  localparam int unsigned SET_W  = $clog2(SETS),
  localparam int unsigned WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1,
  localparam int unsigned LINES  = SETS * WAYS,
  localparam int unsigned LIDX_W = SET_W + WAY_W,
  localparam int unsigned CNT_W  = $clog2(LINES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fill_en,
  input  logic [SET_W-1:0] fill_set,
  input  logic [WAY_W-1:0] fill_way,
  input  logic             store_en,
  input  logic [SET_W-1:0] store_set,
  input  logic [WAY_W-1:0] store_way,
  input  logic             req_valid,
  input  logic [1:0]       req_op,
  input  logic [31:0]      req_operand,
  output logic             req_ready,
  output logic             done,
  output logic [31:0]      status,
  output logic             zflag,
  output logic             wb_req,
  output logic [SET_W-1:0] wb_set,
  output logic [WAY_W-1:0] wb_way,
  input  logic             wb_ack
);
  // Set/way operand decode.
  function automatic logic [WAY_W-1:0] sw_way(input logic [31:0] word);
    return WAY_W'(word >> (32 - WAY_W));
  endfunction
  function automatic logic [SET_W-1:0] sw_set(input logic [31:0] word);
    return SET_W'(word >> 5);
  endfunction

  tcs_state_e        state_q;
  tcs_op_e           op_q;
  logic [31:0]       opnd_q;
  logic [LIDX_W-1:0] tgt_q, ptr_q, sw_idx;
  logic [SET_W-1:0]  sweep_q;
  logic              done_q;
  logic [31:0]       status_q;

  logic              clr_en, clr_inval, sweep_en;
  logic [LIDX_W-1:0] clr_idx;
  logic [LINES-1:0]  valid_vec, dirty_vec;
  logic [CNT_W-1:0]  dirty_cnt, cnt_next;
  logic              found;
  logic [LIDX_W-1:0] pick_idx;

  // Named internal events.
  logic ev_accept, ev_go_wb, ev_fin, ev_start_sweep, ev_sweep_last, ev_now_clean;

  tcs_line_state #(.SETS(SETS), .WAYS(WAYS)) u_lines (
    .clk       (clk),
    .rst_n     (rst_n),
    .fill_en   (fill_en),
    .fill_idx  ({fill_set, fill_way}),
    .store_en  (store_en),
    .store_idx ({store_set, store_way}),
    .clr_en    (clr_en),
    .clr_idx   (clr_idx),
    .clr_inval (clr_inval),
    .sweep_en  (sweep_en),
    .sweep_set (sweep_q),
    .valid_vec (valid_vec),
    .dirty_vec (dirty_vec),
    .dirty_cnt (dirty_cnt),
    .cnt_next  (cnt_next)
  );

  tcs_scan_pick #(.LINES(LINES), .SCAN_LINES(SCAN_LINES)) u_pick (
    .dirty_vec (dirty_vec),
    .ptr       (ptr_q),
    .found     (found),
    .pick_idx  (pick_idx)
  );

  assign sw_idx       = {sw_set(opnd_q), sw_way(opnd_q)};
  assign ev_accept    = (state_q == ST_IDLE) && req_valid;
  assign ev_now_clean = (cnt_next == '0);

  always_comb begin
    ev_go_wb  = 1'b0;
    ev_fin    = 1'b0;
    clr_en    = 1'b0;
    clr_idx   = tgt_q;
    clr_inval = 1'b0;
    sweep_en  = 1'b0;
    case (state_q)
      ST_SCAN: begin
        if (op_is_test(op_q)) begin
          if (found) ev_go_wb = 1'b1;
          else       ev_fin   = 1'b1;
        end else if (dirty_vec[sw_idx]) begin
          ev_go_wb = 1'b1;
        end else begin
          ev_fin = 1'b1;
          if (op_q == OP_LINE_CI) begin
            clr_en    = 1'b1;
            clr_idx   = sw_idx;
            clr_inval = 1'b1;
          end
        end
      end
      ST_WB: begin
        if (wb_ack) begin
          clr_en    = 1'b1;
          clr_inval = (op_q == OP_LINE_CI);
          ev_fin    = 1'b1;
        end
      end
      ST_SWEEP: sweep_en = 1'b1;
      default: ;
    endcase
  end

  assign ev_start_sweep = ev_fin && (op_q == OP_TCI) && ev_now_clean;
  assign ev_sweep_last  = (state_q == ST_SWEEP) && (sweep_q == SET_W'(SETS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      op_q     <= OP_TC;
      opnd_q   <= '0;
      tgt_q    <= '0;
      ptr_q    <= '0;
      sweep_q  <= '0;
      done_q   <= 1'b0;
      status_q <= status_word(1'b1);
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: if (ev_accept) begin
          op_q    <= tcs_op_e'(req_op);
          opnd_q  <= req_operand;
          state_q <= ST_SCAN;
        end
        ST_SCAN: begin
          if (op_is_test(op_q)) begin
            if (found) begin
              tgt_q <= pick_idx;
              ptr_q <= pick_idx + LIDX_W'(1);
            end else begin
              ptr_q <= ptr_q + LIDX_W'(SCAN_LINES);
            end
          end else begin
            tgt_q <= sw_idx;
          end
          if (ev_go_wb) state_q <= ST_WB;
        end
        ST_SWEEP: begin
          sweep_q <= sweep_q + SET_W'(1);
          if (ev_sweep_last) begin
            done_q   <= 1'b1;
            status_q <= status_word(ev_now_clean);
            state_q  <= ST_IDLE;
          end
        end
        default: ;
      endcase
      if (ev_fin) begin
        if (ev_start_sweep) begin
          sweep_q <= '0;
          state_q <= ST_SWEEP;
        end else begin
          done_q   <= 1'b1;
          status_q <= status_word(ev_now_clean);
          state_q  <= ST_IDLE;
        end
      end
    end
  end

  assign req_ready = (state_q == ST_IDLE);
  assign done      = done_q;
  assign status    = status_q;
  assign zflag     = status_q[CLEAN_BIT];
  assign wb_req    = (state_q == ST_WB);
  assign wb_set    = tgt_q[LIDX_W-1:WAY_W];
  assign wb_way    = tgt_q[WAY_W-1:0];
endmodule

// File: rtl/dcache_tclean_seq_chk.sv
module dcache_tclean_seq_chk #(
  parameter int unsigned LINES = 64,
  parameter int unsigned SET_W = 4,
  parameter int unsigned WAY_W = 2,
  parameter int unsigned CNT_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_ready,
  input logic             done,
  input logic [31:0]      status,
  input logic             zflag,
  input logic             wb_req,
  input logic [SET_W-1:0] wb_set,
  input logic [WAY_W-1:0] wb_way,
  input logic             wb_ack,
  input logic [1:0]       op_q,
  input logic [LINES-1:0] valid_vec,
  input logic [LINES-1:0] dirty_vec,
  input logic [CNT_W-1:0] dirty_cnt
);
  p_wb_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wb_req && !wb_ack |=> wb_req && $stable(wb_set) && $stable(wb_way));

  p_wb_dirty_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wb_req |-> dirty_vec[{wb_set, wb_way}]);

  p_cnt_track_r6: assert property (@(posedge clk) disable iff (!rst_n)
    dirty_cnt == CNT_W'($countones(dirty_vec)));

  p_status_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (status[30] == (dirty_cnt == '0)) && (zflag == status[30]));

  p_status_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ((status & ~32'h4000_0000) == 32'h0));

  p_inval_all_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done && (op_q == 2'd1) && status[30] |-> (valid_vec == '0));

  p_done_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> req_ready && !wb_req);
endmodule

bind dcache_tclean_seq dcache_tclean_seq_chk #(
  .LINES(LINES), .SET_W(SET_W), .WAY_W(WAY_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .done(done),
  .status(status), .zflag(zflag), .wb_req(wb_req), .wb_set(wb_set),
  .wb_way(wb_way), .wb_ack(wb_ack), .op_q(op_q), .valid_vec(valid_vec),
  .dirty_vec(dirty_vec), .dirty_cnt(dirty_cnt)
);

// File: tb/sim_dcache_tclean_seq.sv
module sim_dcache_tclean_seq;
  localparam int CLK_PERIOD = 10;
  localparam int SETS = 16, WAYS = 4, SCAN = 4;
  localparam int SET_W = 4, WAY_W = 2, LINES = SETS * WAYS;

  logic clk = 1'b0, rst_n = 1'b0;
  logic fill_en = 0, store_en = 0, req_valid = 0, wb_ack = 0;
  logic [SET_W-1:0] fill_set = 0, store_set = 0;
  logic [WAY_W-1:0] fill_way = 0, store_way = 0;
  logic [1:0] req_op = 0;
  logic [31:0] req_operand = 0;
  logic req_ready, done, zflag, wb_req;
  logic [31:0] status;
  logic [SET_W-1:0] wb_set;
  logic [WAY_W-1:0] wb_way;

  int checks = 0, failures = 0;
  bit mv [LINES];
  bit md [LINES];
  bit wbd [LINES];
  int ptr = 0;
  bit got_wb;
  int got_idx, got_cyc;

  always #(CLK_PERIOD/2) clk = ~clk;

  dcache_tclean_seq #(.SETS(SETS), .WAYS(WAYS), .SCAN_LINES(SCAN)) u0 (
    .clk(clk), .rst_n(rst_n), .fill_en(fill_en), .fill_set(fill_set), .fill_way(fill_way),
    .store_en(store_en), .store_set(store_set), .store_way(store_way),
    .req_valid(req_valid), .req_op(req_op), .req_operand(req_operand),
    .req_ready(req_ready), .done(done), .status(status), .zflag(zflag),
    .wb_req(wb_req), .wb_set(wb_set), .wb_way(wb_way), .wb_ack(wb_ack));

  function automatic int dirty_count();
    int n = 0;
    for (int i = 0; i < LINES; i++) n += int'(md[i]);
    return n;
  endfunction

  function automatic logic [31:0] exp_status(int n);
    return (n == 0) ? 32'h4000_0000 : 32'h0;
  endfunction

  function automatic logic [31:0] mk_operand(int s, int w, logic [31:0] junk);
    logic [31:0] sbz;
    sbz = junk & ~(32'hC000_0000 | (32'hF << 5));
    return (32'(w) << 30) | (32'(s) << 5) | sbz;
  endfunction

  task automatic check(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic fill(int idx);
    @(negedge clk);
    fill_en = 1; fill_set = SET_W'(idx / WAYS); fill_way = WAY_W'(idx % WAYS);
    @(negedge clk);
    fill_en = 0;
    mv[idx] = 1;
  endtask

  task automatic store(int idx);
    @(negedge clk);
    store_en = 1; store_set = SET_W'(idx / WAYS); store_way = WAY_W'(idx % WAYS);
    @(negedge clk);
    store_en = 0;
    if (mv[idx]) md[idx] = 1;
  endtask

  // Issue one request, serve its write-back, update the model, check status.
  task automatic run_req(int op, logic [31:0] opnd);
    int exp_idx, hold, cyc, sidx, sset, sway;
    bit exp_wb, stop;
    exp_wb = 0; exp_idx = -1;
    if (op < 2) begin
      for (int k = SCAN - 1; k >= 0; k--)
        if (md[(ptr + k) % LINES]) begin exp_wb = 1; exp_idx = (ptr + k) % LINES; end
    end else begin
      exp_idx = int'(opnd[31:30]) * WAYS + int'(opnd[8:5]);
      exp_idx = int'(opnd[8:5]) * WAYS + int'(opnd[31:30]);
      exp_wb = md[exp_idx];
    end
    @(negedge clk);
    req_valid = 1; req_op = 2'(op); req_operand = opnd;
    @(negedge clk);
    req_valid = 0;
    got_wb = 0; got_idx = -1; cyc = 1; hold = 0; stop = 0; sset = 0; sway = 0;
    while (!stop) begin
      if (done) stop = 1;
      else begin
        if (req_ready) check(0, "R11 ready while busy", 1, 0);
        if (wb_req) begin
          if (!got_wb) begin
            got_wb = 1; sset = int'(wb_set); sway = int'(wb_way);
            got_idx = sset * WAYS + sway; hold = int'($urandom % 3);
          end else if (int'(wb_set) != sset || int'(wb_way) != sway) begin
            check(0, "R4 wb address stable", longint'(wb_set), longint'(sset));
          end
          if (hold == 0) wb_ack = 1; else hold--;
        end
        @(negedge clk);
        wb_ack = 0;
        cyc++;
        if (cyc > 2000) begin check(0, "R4 request never done", cyc, 0); stop = 1; end
      end
    end
    got_cyc = cyc;
    check(got_wb == exp_wb, "R3 R10 write-back presence", got_wb, exp_wb);
    if (exp_wb) check(got_idx == exp_idx, "R3 R9 write-back line", got_idx, exp_idx);
    if (got_wb && got_idx >= 0) begin
      if (!md[got_idx]) check(0, "R3 wrote back clean line", got_idx, 1);
      if (op < 2) begin
        check(!wbd[got_idx], "R7 line written back once", got_idx, 0);
        wbd[got_idx] = 1;
      end
      md[got_idx] = 0;
    end
    if (op < 2) ptr = got_wb ? (got_idx + 1) % LINES : (ptr + SCAN) % LINES;
    if (op == 3) mv[exp_idx] = 0;
    if (op == 1 && dirty_count() == 0)
      for (int i = 0; i < LINES; i++) mv[i] = 0;
    sidx = dirty_count();
    check(status == exp_status(sidx), "R6 status word", status, exp_status(sidx));
    check(zflag == status[30], "R6 zflag", zflag, status[30]);
    @(negedge clk);
    check(!done, "R4 done one cycle", done, 0);
  endtask

  task automatic random_load(int nfill, int nstore);
    for (int i = 0; i < nfill; i++) fill(int'($urandom % LINES));
    for (int i = 0; i < nstore; i++) store(int'($urandom % LINES));
    for (int i = 0; i < LINES; i++) wbd[i] = 0;
  endtask

  task automatic flush_loop(int op);
    int n = 0;
    bit clean = 0;
    while (!clean && n < 3000) begin
      run_req(op, 32'h0);
      clean = status[30];
      n++;
    end
    check(clean, "R7 flush loop reaches clean", n, 0);
    check(dirty_count() == 0, "R7 no dirty line left", dirty_count(), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    check(0, "watchdog expired", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < LINES; i++) begin mv[i] = 0; md[i] = 0; wbd[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(req_ready && !done && !wb_req, "R1 idle after reset", {req_ready, done, wb_req}, 3'b100);
    check(status == 32'h4000_0000 && zflag, "R1 reset status", status, 32'h4000_0000);

    // R2: store to an invalid line is ignored; R5: no-dirty timing.
    store(9);
    run_req(0, 32'h0);
    check(!got_wb && status[30], "R2 store on invalid line ignored", got_wb, 0);
    check(got_cyc == 2, "R5 done two cycles after accept", got_cyc, 2);

    // R3/R7: random dirty pattern flushed by looping op 0.
    random_load(40, 30);
    flush_loop(0);

    // R9/R10: single-line ops with stray SBZ and word bits.
    fill(5 * WAYS + 2); store(5 * WAYS + 2);
    run_req(2, mk_operand(5, 2, 32'h0010_021F));
    check(got_wb && got_idx == 5 * WAYS + 2, "R9 set/way decode", got_idx, 5 * WAYS + 2);
    run_req(2, mk_operand(5, 2, 32'h0));
    check(!got_wb, "R10 clean line op on clean line", got_wb, 0);
    store(5 * WAYS + 2);
    run_req(3, mk_operand(5, 2, 32'h3FFF_FE1C));
    check(got_wb, "R10 clean+inval writes back", got_wb, 1);
    store(5 * WAYS + 2);
    run_req(2, mk_operand(5, 2, 32'h0));
    check(!got_wb && status[30], "R10 invalidated line ignores store", got_wb, 0);

    // R8: test-clean-invalidate loop, then repeat with nothing dirty.
    random_load(50, 35);
    flush_loop(1);
    run_req(1, 32'h0);
    check(got_cyc == SETS + 2, "R8 sweep one set per cycle", got_cyc, SETS + 2);
    for (int i = 0; i < 8; i++) store(i * 7 % LINES);
    run_req(0, 32'h0);
    check(!got_wb && status[30], "R8 valid bits cleared", got_wb, 0);

    // R3 pointer wrap with a line near the top.
    fill(LINES - 1); store(LINES - 1); fill(1); store(1);
    for (int i = 0; i < LINES; i++) wbd[i] = 0;
    flush_loop(0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule